// File: doc/BRIEF.md
# Shadowed Configuration Register Bank

This block holds the 8-bit configuration registers of a data-converter control path. A serial-interface front end drives it over a byte-wide register bus, with a write strobe and a read strobe. The block drives the active value of every implemented register onto one wide parallel configuration output.

Most registers take effect on the clock edge of their write. A fixed group is double-buffered instead. A write to one of these registers lands in a shadow copy, and the active copy stays unchanged. A master transfer command, a write with bit 0 set to the update address 0xFF, arms a two-state controller. The states are XF_IDLE and XF_ARMED. The transition "arm" goes from XF_IDLE to XF_ARMED when a transfer write is seen. In XF_ARMED the controller commits on the next edge. At that edge every shadow copy moves into its active copy, and the transition "commit" returns the controller to XF_IDLE. A transfer write seen while armed takes the "rearm" transition and stays in XF_ARMED for one more commit. The transfer bit reads back as 1 only while the controller is armed, so it clears itself.

Top module: `shadow_cfg_bank`

## Requirements
- R1: After reset every register holds its default in both copies. Output mode register 0x14 reads 0x01, which selects twos-complement format; 0x00 reads 0x18, 0x01 reads 0x5A, 0x02 reads 0x03, 0x09 reads 0x01, and all others read 0x00.
- R2: A write to a non-shadowed implemented register changes its slice of cfg_o on the same clock edge as the write strobe.
- R3: A write to a shadowed address (0x09, 0x0B, 0x14, 0x18, 0x3A to 0x4C) leaves cfg_o unchanged until a transfer commits it.
- R4: A write to 0xFF with bit 0 set arms the transfer. On the next edge all shadowed registers load their shadow values together. A read of 0xFF returns 0x01 while the transfer is armed and 0x00 once it has committed.
- R5: A write to 0xFF with bit 0 clear starts no transfer and changes no output.
- R6: If a shadowed register is written on the commit edge, the value written on that edge is the value committed.
- R7: Reads are registered. rd_data takes the addressed value on the edge where rd_en is sampled high and holds it otherwise. A shadowed address returns its shadow value.
- R8: Bits outside a register's implemented mask read back as 0 and drive 0 on cfg_o. The masks are: 0x00:0x3C, 0x01:0xFF, 0x02:0x0F, 0x08:0x23, 0x09:0x01, 0x0B:0x07, 0x0D:0xBF, 0x10:0xFF, 0x14:0xF7, 0x15:0x0F, 0x18:0x1F, 0x3A to 0x4C:0xFF, 0xA8:0x0F.
- R9: A write to an address not listed in R8 and not 0xFF has no effect, and a read of such an address returns 0x00.
- R10: cfg_o packs the implemented registers in ascending address order. The register with the k-th lowest address occupies bits [8k+7:8k], so 0x00 is bits [7:0] and 0xA8 is the top byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 8 | Write address |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 8 | Read address |
| rd_data | output | 8 | Registered read data |
| cfg_o | output | 248 | Active values of the 31 implemented registers, packed per R10 |

## Verification
The hardest case to reach is a shadowed write that lands on the exact edge where an armed transfer commits. Hitting it needs a transfer write and then, on the very next cycle, a write to a shadowed address. A rearm can also overlap the commit. Directed sequences build both orderings on purpose. The random phase then sends about a quarter of its writes to 0xFF and draws the rest mostly from the low address range, so back-to-back arm and shadow-write pairs recur many times. Every random cycle compares cfg_o and rd_data against a bench-side model.

// File: rtl/shcfg_pkg.sv
package shcfg_pkg;

    localparam int DATA_W   = 8;
    localparam int ADDR_W   = 8;
    localparam int NUM_ADDR = 1 << ADDR_W;
    localparam logic [ADDR_W-1:0] XFER_ADDR = 8'hFF;
    localparam int XFER_BIT = 0;

    // Implemented bits per address; zero means the address is not implemented.
    function automatic logic [DATA_W-1:0] reg_mask(input logic [ADDR_W-1:0] a);
        if (a >= 8'h3A && a <= 8'h4C) return 8'hFF;
        case (a)
            8'h00:   return 8'h3C;
            8'h01:   return 8'hFF;
            8'h02:   return 8'h0F;
            8'h08:   return 8'h23;
            8'h09:   return 8'h01;
            8'h0B:   return 8'h07;
            8'h0D:   return 8'hBF;
            8'h10:   return 8'hFF;
            8'h14:   return 8'hF7;
            8'h15:   return 8'h0F;
            8'h18:   return 8'h1F;
            8'hA8:   return 8'h0F;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic reg_shadowed(input logic [ADDR_W-1:0] a);
        if (a >= 8'h3A && a <= 8'h4C) return 1'b1;
        return (a == 8'h09) || (a == 8'h0B) || (a == 8'h14) || (a == 8'h18);
    endfunction

    function automatic logic [DATA_W-1:0] reg_default(input logic [ADDR_W-1:0] a);
        case (a)
            8'h00:   return 8'h18;
            8'h01:   return 8'h5A;
            8'h02:   return 8'h03;
            8'h09:   return 8'h01;
            8'h14:   return 8'h01;
            default: return 8'h00;
        endcase
    endfunction

    // Bits that read back at an address, including the transfer bit.
    function automatic logic [DATA_W-1:0] read_mask(input logic [ADDR_W-1:0] a);
        if (a == XFER_ADDR) return DATA_W'(1) << XFER_BIT;
        return reg_mask(a);
    endfunction

    function automatic int count_regs();
        int n = 0;
        for (int a = 0; a < NUM_ADDR; a++)
            if (reg_mask(ADDR_W'(a)) != '0) n++;
        return n;
    endfunction

    localparam int N_REGS = count_regs();
    localparam int CFG_W  = N_REGS * DATA_W;

    function automatic int slot_of(input logic [ADDR_W-1:0] a);
        int n = 0;
        for (int b = 0; b < NUM_ADDR; b++)
            if (b < int'(a) && reg_mask(ADDR_W'(b)) != '0) n++;
        return n;
    endfunction

    function automatic logic [ADDR_W-1:0] addr_of_slot(input int s);
        int k = 0;
        for (int a = 0; a < NUM_ADDR; a++) begin
            if (reg_mask(ADDR_W'(a)) != '0) begin
                if (k == s) return ADDR_W'(a);
                k++;
            end
        end
        return '0;
    endfunction

    // Bit map of cfg_o lanes that belong to shadowed registers.
    function automatic logic [CFG_W-1:0] shadow_lanes();
        logic [CFG_W-1:0] m = '0;
        for (int s = 0; s < N_REGS; s++)
            if (reg_shadowed(addr_of_slot(s))) m[s*DATA_W +: DATA_W] = '1;
        return m;
    endfunction

endpackage

// File: rtl/shcfg_cell.sv
module shcfg_cell
    import shcfg_pkg::*;
#(
    parameter bit                SHADOWED = 1'b0,
    parameter logic [DATA_W-1:0] MASK     = '1,
    parameter logic [DATA_W-1:0] RST_VAL  = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_hit,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              commit,
    output logic [DATA_W-1:0] rb_q,
    output logic [DATA_W-1:0] act_q
);

    localparam logic [DATA_W-1:0] RST_M = RST_VAL & MASK;

    logic [DATA_W-1:0] wval;
    logic [DATA_W-1:0] shd_q;

    assign wval = wr_data & MASK;

    // Shadow copy: only shadowed cells capture host writes here.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shd_q <= RST_M;
        end else if (SHADOWED && wr_hit) begin
            shd_q <= wval;
        end
    end

    // Active copy: shadowed cells load on commit (a same-edge write wins),
    // the others load directly from the write.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_q <= RST_M;
        end else if (SHADOWED) begin
            if (commit) act_q <= wr_hit ? wval : shd_q;
        end else if (wr_hit) begin
            act_q <= wval;
        end
    end

    generate
        if (SHADOWED) begin : g_rb_shadow
            assign rb_q = shd_q;
        end else begin : g_rb_active
            assign rb_q = act_q;
        end
    endgenerate

endmodule

// File: rtl/shcfg_xfer_fsm.sv
module shcfg_xfer_fsm (
    input  logic clk,
    input  logic rst_n,
    input  logic arm_req,
    output logic commit,
    output logic xfer_flag
);

    typedef enum logic [0:0] {
        XF_IDLE  = 1'b0,
        XF_ARMED = 1'b1
    } xfer_state_e;

    xfer_state_e state_q;
    xfer_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= XF_IDLE;
        else        state_q <= state_d;
    end

    // Transitions: arm (IDLE->ARMED), commit (ARMED->IDLE), rearm (ARMED->ARMED).
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            XF_IDLE:  state_d = arm_req ? XF_ARMED : XF_IDLE;
            XF_ARMED: state_d = arm_req ? XF_ARMED : XF_IDLE;
            default:  state_d = XF_IDLE;
        endcase
    end

    always_comb begin
        commit    = 1'b0;
        xfer_flag = 1'b0;
        unique case (state_q)
            XF_IDLE:  begin
                commit    = 1'b0;
                xfer_flag = 1'b0;
            end
            XF_ARMED: begin
                commit    = 1'b1;
                xfer_flag = 1'b1;
            end
            default:  begin
                commit    = 1'b0;
                xfer_flag = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/shcfg_rdmux.sv
module shcfg_rdmux
    import shcfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [CFG_W-1:0]  rb_flat,
    input  logic              xfer_flag,
    output logic [DATA_W-1:0] rd_data
);

    logic [N_REGS-1:0] hit;
    logic [DATA_W-1:0] pick;

    genvar s;
    generate
        for (s = 0; s < N_REGS; s++) begin : g_hit
            localparam logic [ADDR_W-1:0] SLOT_ADDR = addr_of_slot(s);
            assign hit[s] = (rd_addr == SLOT_ADDR);
        end
    endgenerate

    always_comb begin
        pick = '0;
        for (int k = 0; k < N_REGS; k++)
            pick |= {DATA_W{hit[k]}} & rb_flat[k*DATA_W +: DATA_W];
        if (rd_addr == XFER_ADDR)
            pick = DATA_W'(xfer_flag) << XFER_BIT;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     rd_data <= '0;
        else if (rd_en) rd_data <= pick;
    end

endmodule

// File: rtl/shadow_cfg_bank.sv
module shadow_cfg_bank
    import shcfg_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [7:0]                  wr_addr,
    input  logic [7:0]                  wr_data,
    input  logic                        rd_en,
    input  logic [7:0]                  rd_addr,
    output logic [7:0]                  rd_data,
    output logic [shcfg_pkg::CFG_W-1:0] cfg_o
);

    logic             arm_req;
    logic             commit;
    logic             xfer_flag;
    logic [CFG_W-1:0] rb_flat;

    assign arm_req = wr_en && (wr_addr == XFER_ADDR) && wr_data[XFER_BIT];

    shcfg_xfer_fsm u_xfer (
        .clk       (clk),
        .rst_n     (rst_n),
        .arm_req   (arm_req),
        .commit    (commit),
        .xfer_flag (xfer_flag)
    );

    genvar s;
    generate
        for (s = 0; s < N_REGS; s++) begin : g_reg
            localparam logic [ADDR_W-1:0] A = addr_of_slot(s);
            logic hit_w;
            assign hit_w = wr_en && (wr_addr == A);

            shcfg_cell #(
                .SHADOWED (reg_shadowed(A)),
                .MASK     (reg_mask(A)),
                .RST_VAL  (reg_default(A))
            ) u_cell (
                .clk     (clk),
                .rst_n   (rst_n),
                .wr_hit  (hit_w),
                .wr_data (wr_data),
                .commit  (commit),
                .rb_q    (rb_flat[s*DATA_W +: DATA_W]),
                .act_q   (cfg_o[s*DATA_W +: DATA_W])
            );
        end
    endgenerate

    shcfg_rdmux u_rd (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_en     (rd_en),
        .rd_addr   (rd_addr),
        .rb_flat   (rb_flat),
        .xfer_flag (xfer_flag),
        .rd_data   (rd_data)
    );

endmodule

// File: rtl/shcfg_chk.sv
module shcfg_chk
    import shcfg_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [7:0]       wr_addr,
    input logic [7:0]       wr_data,
    input logic             rd_en,
    input logic [7:0]       rd_addr,
    input logic [7:0]       rd_data,
    input logic [CFG_W-1:0] cfg_o
);

    localparam logic [CFG_W-1:0] SH_LANES = shadow_lanes();
    localparam int SLOT0 = slot_of(8'h00);

    logic arm;
    assign arm = wr_en && (wr_addr == XFER_ADDR) && wr_data[XFER_BIT];

    // R3: shadowed lanes move only on the edge after a transfer write
    a_r3_shadow_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(arm, 2) |-> ((cfg_o & SH_LANES) == ($past(cfg_o) & SH_LANES)));

    // R4: transfer bit reads 1 only for the cycle after the arming write
    a_r4_flag_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rd_en && rd_addr == XFER_ADDR) |-> (rd_data == {7'b0, $past(arm, 2)}));

    // R2: immediate register takes the written value on the write edge
    a_r2_immediate: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_en && wr_addr == 8'h00) |->
            (cfg_o[SLOT0*DATA_W +: DATA_W] == ($past(wr_data) & reg_mask(8'h00))));

    // R8: unimplemented bits never read back as 1
    a_r8_unimpl_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rd_en) |-> ((rd_data & ~read_mask($past(rd_addr))) == 8'h00));

    // R7: read data holds when no read is strobed
    a_r7_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rd_en) |-> $stable(rd_data));

endmodule

bind shadow_cfg_bank shcfg_chk chk_i (.*);

// File: tb/shadow_cfg_bank_tb_top.sv
module shadow_cfg_bank_tb_top;

    function automatic logic [7:0] b_mask(input logic [7:0] a);
        if (a >= 8'h3A && a <= 8'h4C) return 8'hFF;
        case (a)
            8'h00: return 8'h3C;  8'h01: return 8'hFF;  8'h02: return 8'h0F;
            8'h08: return 8'h23;  8'h09: return 8'h01;  8'h0B: return 8'h07;
            8'h0D: return 8'hBF;  8'h10: return 8'hFF;  8'h14: return 8'hF7;
            8'h15: return 8'h0F;  8'h18: return 8'h1F;  8'hA8: return 8'h0F;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic b_shadow(input logic [7:0] a);
        return (a == 8'h09) || (a == 8'h0B) || (a == 8'h14) || (a == 8'h18) ||
               (a >= 8'h3A && a <= 8'h4C);
    endfunction

    function automatic logic [7:0] b_default(input logic [7:0] a);
        case (a)
            8'h00: return 8'h18;  8'h01: return 8'h5A;  8'h02: return 8'h03;
            8'h09: return 8'h01;  8'h14: return 8'h01;
            default: return 8'h00;
        endcase
    endfunction

    function automatic int b_count();
        int n = 0;
        for (int a = 0; a < 256; a++) if (b_mask(8'(a)) != 0) n++;
        return n;
    endfunction

    localparam int NB = b_count();
    localparam int CW = NB * 8;

    function automatic int b_slot(input logic [7:0] a);
        int n = 0;
        for (int b = 0; b < int'(a); b++) if (b_mask(8'(b)) != 0) n++;
        return n;
    endfunction

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [7:0]    wr_addr = '0;
    logic [7:0]    wr_data = '0;
    logic          rd_en = 1'b0;
    logic [7:0]    rd_addr = '0;
    logic [7:0]    rd_data;
    logic [CW-1:0] cfg_o;

    always #5 clk = ~clk;

    shadow_cfg_bank dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_data(rd_data), .cfg_o(cfg_o)
    );

    logic [7:0] m_sh  [256];
    logic [7:0] m_act [256];
    logic       m_armed;
    logic [7:0] m_rd;
    int n_cmp = 0;
    int n_bad = 0;

    function automatic logic [CW-1:0] exp_cfg();
        logic [CW-1:0] v = '0;
        int k = 0;
        for (int a = 0; a < 256; a++) begin
            if (b_mask(8'(a)) != 0) begin
                v[k*8 +: 8] = m_act[a];
                k++;
            end
        end
        return v;
    endfunction

    function automatic logic [7:0] lane(input logic [7:0] a);
        return cfg_o[b_slot(a)*8 +: 8];
    endfunction

    task automatic chk(input string req, input logic [255:0] act, input logic [255:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int a = 0; a < 256; a++) begin
            m_sh[a]  = b_default(8'(a)) & b_mask(8'(a));
            m_act[a] = b_default(8'(a)) & b_mask(8'(a));
        end
        m_armed = 1'b0;
        m_rd    = 8'h00;
    endtask

    task automatic model_edge(input bit we, input logic [7:0] wa, input logic [7:0] wd,
                              input bit re, input logic [7:0] ra);
        bit commit = m_armed;
        logic [7:0] mk = b_mask(wa);
        if (re) begin
            if (ra == 8'hFF)       m_rd = {7'b0, m_armed};
            else if (b_shadow(ra)) m_rd = m_sh[ra];
            else                   m_rd = m_act[ra];
        end
        m_armed = we && (wa == 8'hFF) && wd[0];
        if (we && mk != 0) begin
            if (b_shadow(wa)) m_sh[wa]  = wd & mk;
            else              m_act[wa] = wd & mk;
        end
        if (commit)
            for (int a = 0; a < 256; a++)
                if (b_shadow(8'(a))) m_act[a] = m_sh[a];
    endtask

    task automatic step(input string tag, input bit we, input logic [7:0] wa,
                        input logic [7:0] wd, input bit re, input logic [7:0] ra);
        @(negedge clk);
        wr_en = we; wr_addr = wa; wr_data = wd; rd_en = re; rd_addr = ra;
        @(posedge clk);
        model_edge(we, wa, wd, re, ra);
        #1;
        chk({tag, " cfg_o"}, 256'(cfg_o), 256'(exp_cfg()));
        chk({tag, " rd_data"}, 256'(rd_data), 256'(m_rd));
    endtask

    task automatic idle(input string tag);
        step(tag, 1'b0, 8'h00, 8'h00, 1'b0, 8'h00);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int unsigned seed = 32'h0005EED5;
        void'($urandom(seed));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: defaults on outputs and read data after reset
        chk("R1 cfg_o defaults", 256'(cfg_o), 256'(exp_cfg()));
        chk("R1 rd_data reset", 256'(rd_data), 256'(8'h00));
        step("R1", 0, 8'h00, 8'h00, 1, 8'h14);
        chk("R1 output mode default", 256'(rd_data), 256'(8'h01));
        chk("R1 output mode lane", 256'(lane(8'h14)), 256'(8'h01));

        // R2: immediate register
        step("R2", 1, 8'h00, 8'hFF, 0, 8'h00);
        chk("R2 immediate lane", 256'(lane(8'h00)), 256'(8'h3C));

        // R3: shadowed write held back
        step("R3", 1, 8'h14, 8'hAA, 0, 8'h00);
        chk("R3 lane unchanged", 256'(lane(8'h14)), 256'(8'h01));
        // R7: shadowed read returns shadow value
        step("R7", 0, 8'h00, 8'h00, 1, 8'h14);
        chk("R7 shadow readback", 256'(rd_data), 256'(8'hA2));
        idle("R7 hold");
        chk("R7 rd_data held", 256'(rd_data), 256'(8'hA2));

        // R5: transfer write with bit 0 clear
        step("R5", 1, 8'hFF, 8'hFE, 0, 8'h00);
        step("R5", 0, 8'h00, 8'h00, 1, 8'hFF);
        chk("R5 no commit", 256'(lane(8'h14)), 256'(8'h01));
        chk("R5 flag clear", 256'(rd_data), 256'(8'h00));

        // R4: arm, commit, auto-clear
        step("R4 arm", 1, 8'hFF, 8'h01, 0, 8'h00);
        step("R4 commit", 0, 8'h00, 8'h00, 1, 8'hFF);
        chk("R4 flag while armed", 256'(rd_data), 256'(8'h01));
        chk("R4 committed lane", 256'(lane(8'h14)), 256'(8'hA2));
        step("R4 clear", 0, 8'h00, 8'h00, 1, 8'hFF);
        chk("R4 flag cleared", 256'(rd_data), 256'(8'h00));

        // R6: shadowed write on commit edge wins
        step("R6", 1, 8'h3A, 8'h11, 0, 8'h00);
        step("R6 arm", 1, 8'hFF, 8'h01, 0, 8'h00);
        step("R6 late write", 1, 8'h3A, 8'h77, 0, 8'h00);
        chk("R6 committed value", 256'(lane(8'h3A)), 256'(8'h77));

        // R8: unimplemented bits
        step("R8", 1, 8'h02, 8'hFF, 1, 8'h02);
        step("R8", 0, 8'h00, 8'h00, 1, 8'h02);
        chk("R8 masked readback", 256'(rd_data), 256'(8'h0F));
        chk("R8 masked lane", 256'(lane(8'h02)), 256'(8'h0F));

        // R9: unsupported address
        step("R9", 1, 8'h05, 8'h5A, 0, 8'h00);
        step("R9", 0, 8'h00, 8'h00, 1, 8'h05);
        chk("R9 unsupported read", 256'(rd_data), 256'(8'h00));

        // R10: packing order, top byte is 0xA8
        step("R10", 1, 8'hA8, 8'hFF, 0, 8'h00);
        chk("R10 top lane", 256'(cfg_o[CW-1 -: 8]), 256'(8'h0F));
        chk("R10 lane count", 256'(NB), 256'(31));

        // random mix
        for (int i = 0; i < 3000; i++) begin
            bit we = ($urandom % 4) != 0;
            bit re = ($urandom % 2) != 0;
            logic [7:0] wa;
            logic [7:0] wd = 8'($urandom);
            logic [7:0] ra = ($urandom % 3 == 0) ? 8'($urandom) : 8'($urandom % 8'h50);
            int pick = $urandom % 8;
            if (pick < 2)      wa = 8'hFF;
            else if (pick < 6) wa = 8'($urandom % 8'h50);
            else               wa = 8'($urandom);
            if ($urandom % 8 == 0) ra = 8'hFF;
            step("R3/R4/R6 random", we, wa, wd, re, ra);
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule